// File: doc/BRIEF.md
# Interrupt Controller Wake-Sleep Manager

This block keeps the power-management state that a multi-core interrupt distributor needs before cores, and finally the distributor itself, are powered down. For each core it holds a processor-sleep flag and derives a children-asleep flag. Alongside those it holds one global sleep bit and a quiescent flag. Writes that would break the power-down ordering are dropped, so software cannot release a core while the distributor is going to sleep, and it cannot put the distributor to sleep while any core still has traffic in flight.

The block watches the stream interface toward each core. It counts transfers that are accepted (valid and ready both high) and subtracts acknowledges, which gives it the number of transfers still outstanding. The block only observes this stream. It never drives ready and never stalls a transfer, so back-pressure stays entirely between the distributor and the core. Incoming interrupts arrive on a plain qualifier. A targeted interrupt names exactly one core. A multi-target interrupt offers a set of eligible cores, and the block picks one delivery core using the cpu_active hints. A sleeping core that receives a targeted interrupt gets a wake request toward the power controller. Per cluster, the block also reports when the cluster's stream port may be power gated.

Top module: `irq_wake_sleep_mgr`

## Requirements
- R1: A write of 1 to the global sleep bit takes effect at the next clock edge only if every core's proc_sleep and every core's children_asleep is 1; otherwise sleep keeps its old value.
- R2: A write of 0 to sleep always takes effect at the next edge, and sleep is one bit shared by all cores.
- R3: A write of 1 to a core's proc_sleep always takes effect at the next edge. A write of 0 takes effect only while sleep is 0 and quiescent is 0; otherwise it is ignored.
- R4: Each core's outstanding count rises by one on a cycle where tx_valid and tx_ready are both high and falls by one on tx_ack. children_asleep is 1 exactly when proc_sleep is 1 and that count is zero.
- R5: quiescent rises one edge after sleep becomes 1, provided all counts are zero. It falls at the same edge at which sleep clears.
- R6: A targeted interrupt (irq_multi = 0, irq_target one-hot) to a core whose proc_sleep is 1 sets that core's wake_request at the next edge. The request holds until proc_sleep is cleared. Multi-target interrupts never set wake_request.
- R7: A targeted interrupt is delivered on deliver to its target whenever that core's proc_sleep is 0, regardless of cpu_active. It is not delivered while proc_sleep is 1.
- R8: For a multi-target interrupt, the eligible cores are the target bits whose proc_sleep is 0. deliver is the lowest-index eligible core with cpu_active high, or, if no eligible core is active, the lowest-index eligible core. deliver is all zero when nothing is eligible. deliver is combinational in the same cycle.
- R9: gate_ok[c] is 1 exactly when every core of cluster c (cores c*CLUSTER_CORES upward) has children_asleep at 1.
- R10: After reset, every flag, count, wake_request and gate_ok is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps_wr_en | input | 1 | Write strobe for one core's proc_sleep |
| ps_wr_core | input | CIDX_W | Core index for the proc_sleep write |
| ps_wr_val | input | 1 | Value written to proc_sleep |
| sl_wr_en | input | 1 | Write strobe for the global sleep bit |
| sl_wr_val | input | 1 | Value written to sleep |
| tx_valid | input | NUM_CORES | Stream valid toward each core (observed) |
| tx_ready | input | NUM_CORES | Stream ready from each core (observed) |
| tx_ack | input | NUM_CORES | Acknowledge retiring one outstanding transfer |
| cpu_active | input | NUM_CORES | Per-core activity hint for multi-target routing |
| irq_valid | input | 1 | Interrupt present this cycle |
| irq_multi | input | 1 | 1: multi-target, 0: targeted at one core |
| irq_target | input | NUM_CORES | Target core (one-hot) or eligible set |
| deliver | output | NUM_CORES | One-hot core chosen for stream delivery |
| wake_request | output | NUM_CORES | Wake request to the power controller |
| proc_sleep | output | NUM_CORES | Per-core processor-sleep flag |
| children_asleep | output | NUM_CORES | Per-core sleep handshake complete |
| sleep | output | 1 | Global sleep bit |
| quiescent | output | 1 | Distributor drained while asleep |
| gate_ok | output | NUM_CLUSTERS | Cluster stream port may be power gated |

## Verification
deliver is combinational, so the bench drives the interrupt on a falling edge and reads deliver a nanosecond later within the same cycle. Every register write, and every transfer or acknowledge, shows on proc_sleep, children_asleep, sleep, gate_ok or wake_request one edge later, so the bench holds the stimulus across exactly one rising edge and reads the result at the next falling edge. quiescent lags sleep by one further edge. The bench samples once right after sleep rises, expecting it low, and again one cycle later, expecting it high.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/wsm_core_slot.sv
module wsm_core_slot #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ps_wr_en,
  input  logic ps_wr_val,
  input  logic clr_allowed,
  input  logic tx_fire,
  input  logic tx_ack,
  input  logic irq_hit,
  output logic psleep,
  output logic drained,
  output logic kids_asleep,
  output logic wake
);
  logic [CNT_W-1:0] cnt_q;
  logic             ps_q, ps_d;
  logic             wake_q, wake_d;

  always_comb begin
    ps_d = ps_q;
    if (ps_wr_en) begin
      if (ps_wr_val)        ps_d = 1'b1;
      else if (clr_allowed) ps_d = 1'b0;
    end
    // a clear wins over a same-cycle hit; a hit only counts while asleep
    wake_d = ps_d & (wake_q | (irq_hit & ps_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= 1'b0;
      wake_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ps_q   <= ps_d;
      wake_q <= wake_d;
      case ({tx_fire, tx_ack})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign psleep      = ps_q;
  assign drained     = (cnt_q == '0);
  assign kids_asleep = ps_q & drained;
  assign wake        = wake_q;
endmodule

// File: rtl/wsm_global.sv
module wsm_global (
  input  logic clk,
  input  logic rst_n,
  input  logic sl_wr_en,
  input  logic sl_wr_val,
  input  logic all_asleep,
  input  logic all_drained,
  output logic sleep,
  output logic quiescent
);
  logic sleep_q, sleep_d, quiet_q;

  always_comb begin
    sleep_d = sleep_q;
    if (sl_wr_en) sleep_d = sl_wr_val ? (all_asleep | sleep_q) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      quiet_q <= 1'b0;
    end else begin
      sleep_q <= sleep_d;
      quiet_q <= sleep_q & sleep_d & all_drained;
    end
  end

  assign sleep     = sleep_q;
  assign quiescent = quiet_q;
endmodule

// File: rtl/wsm_router.sv
module wsm_router #(
  parameter int N = 4
) (
  input  logic         irq_valid,
  input  logic         irq_multi,
  input  logic [N-1:0] irq_target,
  input  logic [N-1:0] cpu_active,
  input  logic [N-1:0] psleep,
  output logic [N-1:0] deliver
);
  logic [N-1:0] elig, pref, pick;

  always_comb begin
    elig = irq_target & ~psleep & {N{irq_valid}};
    pref = elig & cpu_active;
    pick = (pref != '0) ? pref : elig;
    if (irq_multi) deliver = pick & (~pick + 1'b1);
    else           deliver = elig;
  end
endmodule

// File: rtl/irq_wake_sleep_mgr.sv
module irq_wake_sleep_mgr
  import wsm_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int CLUSTER_CORES = 2,
  parameter int CNT_W         = 4,
  localparam int CIDX_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int NUM_CLUSTERS = ceil_div(NUM_CORES, CLUSTER_CORES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ps_wr_en,
  input  logic [CIDX_W-1:0]       ps_wr_core,
  input  logic                    ps_wr_val,
  input  logic                    sl_wr_en,
  input  logic                    sl_wr_val,
  input  logic [NUM_CORES-1:0]    tx_valid,
  input  logic [NUM_CORES-1:0]    tx_ready,
  input  logic [NUM_CORES-1:0]    tx_ack,
  input  logic [NUM_CORES-1:0]    cpu_active,
  input  logic                    irq_valid,
  input  logic                    irq_multi,
  input  logic [NUM_CORES-1:0]    irq_target,
  output logic [NUM_CORES-1:0]    deliver,
  output logic [NUM_CORES-1:0]    wake_request,
  output logic [NUM_CORES-1:0]    proc_sleep,
  output logic [NUM_CORES-1:0]    children_asleep,
  output logic                    sleep,
  output logic                    quiescent,
  output logic [NUM_CLUSTERS-1:0] gate_ok
);
  logic [NUM_CORES-1:0] drained;
  logic                 clr_allowed;

  assign clr_allowed = ~sleep & ~quiescent;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    localparam logic [NUM_CORES-1:0] SEL = NUM_CORES'(1) << i;
    logic hit, wr_here;
    assign hit     = irq_valid & ~irq_multi & (irq_target == SEL);
    assign wr_here = ps_wr_en & (ps_wr_core == CIDX_W'(i));

    wsm_core_slot #(.CNT_W(CNT_W)) slot_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ps_wr_en    (wr_here),
      .ps_wr_val   (ps_wr_val),
      .clr_allowed (clr_allowed),
      .tx_fire     (tx_valid[i] & tx_ready[i]),
      .tx_ack      (tx_ack[i]),
      .irq_hit     (hit),
      .psleep      (proc_sleep[i]),
      .drained     (drained[i]),
      .kids_asleep (children_asleep[i]),
      .wake        (wake_request[i])
    );
  end

  wsm_global glob_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sl_wr_en    (sl_wr_en),
    .sl_wr_val   (sl_wr_val),
    .all_asleep  (&(proc_sleep & children_asleep)),
    .all_drained (&drained),
    .sleep       (sleep),
    .quiescent   (quiescent)
  );

  wsm_router #(.N(NUM_CORES)) route_i (
    .irq_valid  (irq_valid),
    .irq_multi  (irq_multi),
    .irq_target (irq_target),
    .cpu_active (cpu_active),
    .psleep     (proc_sleep),
    .deliver    (deliver)
  );

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_clu
    localparam int LO = c * CLUSTER_CORES;
    localparam int HI = (LO + CLUSTER_CORES > NUM_CORES) ? NUM_CORES : LO + CLUSTER_CORES;
    assign gate_ok[c] = &children_asleep[HI-1:LO];
  end
endmodule

// File: rtl/wsm_checker.sv
module wsm_checker #(
  parameter int N  = 4,
  parameter int NC = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] deliver,
  input logic [N-1:0] wake_request,
  input logic [N-1:0] proc_sleep,
  input logic [N-1:0] children_asleep,
  input logic         sleep,
  input logic         quiescent,
  input logic         irq_valid,
  input logic         irq_multi
);
  p_sleep_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(&children_asleep));

  p_quiet_in_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quiescent |-> sleep);

  p_deliver_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_multi) |-> $onehot0(deliver));

  p_no_deliver_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver & proc_sleep) == '0);

  for (genvar i = 0; i < N; i++) begin : g_core
    p_clear_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(proc_sleep[i]) |-> $past(!sleep && !quiescent));

    p_wake_only_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_request[i] |-> proc_sleep[i]);

    p_kids_need_ps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      children_asleep[i] |-> proc_sleep[i]);
  end
endmodule

bind irq_wake_sleep_mgr wsm_checker #(.N(NUM_CORES), .NC(NUM_CLUSTERS)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .deliver         (deliver),
  .wake_request    (wake_request),
  .proc_sleep      (proc_sleep),
  .children_asleep (children_asleep),
  .sleep           (sleep),
  .quiescent       (quiescent),
  .irq_valid       (irq_valid),
  .irq_multi       (irq_multi)
);

// File: tb/irq_wake_sleep_mgr_tb_top.sv
`timescale 1ns/1ps
module irq_wake_sleep_mgr_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps_wr_en = 0, ps_wr_val = 0, sl_wr_en = 0, sl_wr_val = 0;
  logic [1:0] ps_wr_core = '0;
  logic [N-1:0] tx_valid = '0, tx_ready = '0, tx_ack = '0, cpu_active = '0, irq_target = '0;
  logic irq_valid = 0, irq_multi = 0;
  logic [N-1:0] deliver, wake_request, proc_sleep, children_asleep;
  logic sleep, quiescent;
  logic [1:0] gate_ok;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_wake_sleep_mgr dut_i (.*);

  // {multi, target, active, expected deliver}; core 3 is asleep during the walk
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 4'b0001, 4'b0000, 4'b0001},
    {1'b0, 4'b0100, 4'b1111, 4'b0100},
    {1'b0, 4'b1000, 4'b1111, 4'b0000},
    {1'b1, 4'b1111, 4'b0000, 4'b0001},
    {1'b1, 4'b1111, 4'b0100, 4'b0100},
    {1'b1, 4'b0110, 4'b1001, 4'b0010},
    {1'b1, 4'b1010, 4'b1000, 4'b0010},
    {1'b1, 4'b1000, 4'b1111, 4'b0000},
    {1'b1, 4'b0000, 4'b1111, 4'b0000},
    {1'b1, 4'b1110, 4'b1010, 4'b0010}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ps_write(input int core, input logic val);
    @(negedge clk);
    ps_wr_en = 1; ps_wr_core = 2'(core); ps_wr_val = val;
    @(negedge clk);
    ps_wr_en = 0;
  endtask

  task automatic sl_write(input logic val);
    @(negedge clk);
    sl_wr_en = 1; sl_wr_val = val;
    @(negedge clk);
    sl_wr_en = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 reset", {proc_sleep, children_asleep}, 8'h00);
    chk("R10 reset", {wake_request, 2'b00, sleep, quiescent}, 8'h00);
    chk("R10 reset", {6'd0, gate_ok}, 8'h00);

    ps_write(3, 1'b1);
    chk("R3 set ps", {4'd0, proc_sleep}, 8'h08);
    chk("R4 kids", {4'd0, children_asleep}, 8'h08);

    // table walk: routing per R7/R8; entry 2 hits sleeping core 3 (R6)
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      irq_valid = 1; irq_multi = VEC[k][12]; irq_target = VEC[k][11:8]; cpu_active = VEC[k][7:4];
      #1;
      chk(VEC[k][12] ? "R8 multi route" : "R7 targeted route", {4'd0, deliver}, {4'd0, VEC[k][3:0]});
    end
    @(negedge clk);
    irq_valid = 0;
    chk("R6 wake set", {4'd0, wake_request}, 8'h08);

    ps_write(2, 1'b1);
    @(negedge clk);
    irq_valid = 1; irq_multi = 1; irq_target = 4'b0100; #1;
    chk("R8 none eligible", {4'd0, deliver}, 8'h00);
    @(negedge clk);
    irq_valid = 0;
    chk("R6 multi no wake", {4'd0, wake_request}, 8'h08);
    chk("R9 cluster1 gate", {6'd0, gate_ok}, 8'h02);

    sl_write(1'b1);
    chk("R1 sleep refused", {7'd0, sleep}, 8'h00);

    @(negedge clk);
    tx_valid[0] = 1; tx_ready[0] = 1;
    @(negedge clk);
    @(negedge clk);
    tx_valid[0] = 0; tx_ready[0] = 0;
    ps_write(0, 1'b1);
    ps_write(1, 1'b1);
    chk("R4 count holds kids", {4'd0, children_asleep}, 8'h0E);
    chk("R9 cluster0 blocked", {6'd0, gate_ok}, 8'h02);
    sl_write(1'b1);
    chk("R1 sleep refused busy", {7'd0, sleep}, 8'h00);

    @(negedge clk);
    tx_ack[0] = 1;
    @(negedge clk);
    chk("R4 one outstanding", {4'd0, children_asleep}, 8'h0E);
    @(negedge clk);
    tx_ack[0] = 0;
    chk("R4 drained", {4'd0, children_asleep}, 8'h0F);
    chk("R9 all gate", {6'd0, gate_ok}, 8'h03);

    sl_write(1'b1);
    chk("R1 sleep taken", {6'd0, sleep, quiescent}, 8'h02);
    @(negedge clk);
    chk("R5 quiescent rises", {6'd0, sleep, quiescent}, 8'h03);

    ps_write(3, 1'b0);
    chk("R3 clear refused", {4'd0, proc_sleep}, 8'h0F);
    chk("R6 wake held", {4'd0, wake_request}, 8'h08);

    sl_write(1'b0);
    chk("R2 R5 sleep clear", {6'd0, sleep, quiescent}, 8'h00);

    ps_write(3, 1'b0);
    chk("R3 clear taken", {4'd0, proc_sleep}, 8'h07);
    chk("R6 wake dropped", {4'd0, wake_request}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule